// File: doc/BRIEF.md
# PLL Fast-Lock Timeout Sequencer

This block steps a fractional-N synthesizer loop from boosted bandwidth down to its final bandwidth after a new channel has been programmed. It runs on the phase-detector reference clock. When the channel register is committed, the register interface sends a one-cycle start pulse. That pulse puts the loop into wide-bandwidth mode: the charge-pump current is boosted and the loop-filter resistor switches are closed. It also loads three independent timeout counters. The counts are in reference cycles.

Each counter ends one part of the wide-bandwidth state. The first counter returns the charge-pump current to its normal value. The second counter opens the first and second loop-filter switches, which move together. The third counter opens the third switch on its own schedule. In a typical setup the boost ratio is 8:1 and the current timeout is shorter than the two switch timeouts, so the current drops before the filter zero is reconfigured. A status output stays high from the start until all three events have happened.

Every channel write restarts the whole sequence, even if a previous sequence is still running. The timeout counts are captured at the start, so the configuration registers can be rewritten during a sequence without disturbing it.

Top module: `fastlock_seq`

## Requirements
- R1: While reset is held low on a clock edge, all four outputs (`cp_boost`, `sw12_closed`, `sw3_closed`, `busy`) read 0 after that edge.
- R2: On the clock edge where `start` is sampled high, all four outputs become 1, whatever count values are programmed.
- R3: `cp_boost` stays 1 for exactly `cp_count`+1 reference cycles after the start edge. A count of 0 gives one cycle, and the output falls on the first edge after the start.
- R4: `sw12_closed` stays 1 for exactly `sw12_count`+1 reference cycles after the start edge.
- R5: `sw3_closed` stays 1 for exactly `sw3_count`+1 reference cycles after the start edge.
- R6: A `start` that arrives while a sequence is running reloads all three counters. On that edge all three controls are 1 again, and each window is measured from the new start.
- R7: The counts are captured on the start edge. Changing `cp_count`, `sw12_count` or `sw3_count` later has no effect on the running sequence.
- R8: `busy` is 1 exactly while at least one of the three controls is 1.
- R9: Once a control has fallen, it stays 0 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse raised on each channel-register commit |
| cp_count | input | 10 | Charge-pump boost timeout, in reference cycles |
| sw12_count | input | 10 | Timeout for the first and second filter switches |
| sw3_count | input | 10 | Timeout for the third filter switch |
| cp_boost | output | 1 | 1 = boosted charge-pump current, 0 = normal current |
| sw12_closed | output | 1 | 1 = first and second loop-filter switches closed |
| sw3_closed | output | 1 | 1 = third loop-filter switch closed |
| busy | output | 1 | 1 while any of the three timeouts is still pending |

## Verification
Every output is one register away from its inputs. A start sampled on edge t sets all controls after edge t, and a control with count N reads 1 after edges t through t+N and reads 0 after edge t+N+1. The bench changes inputs on the falling edge, counts rising edges, and reads the outputs on the next falling edge. It compares each output with the window rule above, using the counts the bench itself captured at the last start. The same rule is applied to restarts and to configuration changes made in the middle of a run.

// File: rtl/fastlock_pkg.sv
// Package: shared constants for the fast-lock sequencer.
// Assumes: three timers, in a fixed index order that the top module uses.
package fastlock_pkg;
    localparam int unsigned NUM_TIMERS = 3;
    localparam int unsigned IDX_CP     = 0;
    localparam int unsigned IDX_SW12   = 1;
    localparam int unsigned IDX_SW3    = 2;
endpackage

// File: rtl/fl_timeout.sv
// Module: fl_timeout
// One reference-cycle timeout. A load sets the control output and captures
// the count. The output then stays high for count+1 cycles and clears itself.
// Assumes: load is a single-cycle pulse. A load always wins over a running countdown.
module fl_timeout #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             active
);
    logic [CNT_W-1:0] remain;

    // Countdown: reload on start, step down while active, drop the output at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            active <= 1'b0;
        end else if (load) begin
            remain <= count;
            active <= 1'b1;
        end else if (active) begin
            if (remain == '0) begin
                active <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fl_status.sv
// Module: fl_status
// Reports whether any timeout is still pending.
// Assumes: each bit of act is a registered control from one timer.
module fl_status #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] act,
    output logic         any_active
);
    // Reduction: status follows the OR of all pending timers.
    always_comb begin
        any_active = |act;
    end
endmodule

// File: rtl/fastlock_seq.sv
// Module: fastlock_seq (top)
// Sequences the wide-to-narrow bandwidth step after each channel write.
// Three timeouts run side by side: charge-pump boost, switches 1/2, switch 3.
// Assumes: clk is the phase-detector reference and start lasts one cycle.
module fastlock_seq #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cp_count,
    input  logic [CNT_W-1:0] sw12_count,
    input  logic [CNT_W-1:0] sw3_count,
    output logic             cp_boost,
    output logic             sw12_closed,
    output logic             sw3_closed,
    output logic             busy
);
    import fastlock_pkg::*;

    localparam int unsigned NT = NUM_TIMERS;

    logic [NT-1:0][CNT_W-1:0] counts;
    logic [NT-1:0]            act;

    // Routing: put the configured counts in timer index order.
    always_comb begin
        counts           = '0;
        counts[IDX_CP]   = cp_count;
        counts[IDX_SW12] = sw12_count;
        counts[IDX_SW3]  = sw3_count;
    end

    for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
        fl_timeout #(.CNT_W(CNT_W)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (start),
            .count  (counts[gi]),
            .active (act[gi])
        );
    end

    fl_status #(.N(NT)) u_stat (
        .act        (act),
        .any_active (busy)
    );

    // Output mapping: drive the named controls from the timer flags.
    always_comb begin
        cp_boost    = act[IDX_CP];
        sw12_closed = act[IDX_SW12];
        sw3_closed  = act[IDX_SW3];
    end
endmodule

// File: rtl/fastlock_seq_chk.sv
// Module: fastlock_seq_chk
// Property checker for fastlock_seq. It keeps its own count of edges since
// the last start and its own copy of the counts captured at that start.
module fastlock_seq_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] cp_count,
    input logic [CNT_W-1:0] sw12_count,
    input logic [CNT_W-1:0] sw3_count,
    input logic             cp_boost,
    input logic             sw12_closed,
    input logic             sw3_closed,
    input logic             busy
);
    localparam int unsigned RW = CNT_W + 1;

    logic             started;
    logic [RW-1:0]    run;
    logic [CNT_W-1:0] lat_cp, lat_12, lat_3;

    // Shadow state: edges since the last start (saturating) and the captured counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            run     <= '0;
            lat_cp  <= '0;
            lat_12  <= '0;
            lat_3   <= '0;
        end else if (start) begin
            started <= 1'b1;
            run     <= '0;
            lat_cp  <= cp_count;
            lat_12  <= sw12_count;
            lat_3   <= sw3_count;
        end else if (run != {RW{1'b1}}) begin
            run <= run + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!cp_boost && !sw12_closed && !sw3_closed && !busy));

    p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cp_boost && sw12_closed && sw3_closed && busy));

    p_cp_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (cp_boost == (run <= RW'(lat_cp))));

    p_sw12_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (sw12_closed == (run <= RW'(lat_12))));

    p_sw3_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (sw3_closed == (run <= RW'(lat_3))));

    p_busy_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (cp_boost || sw12_closed || sw3_closed));

    p_stay_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !cp_boost && !sw12_closed && !sw3_closed)
            |=> (!cp_boost && !sw12_closed && !sw3_closed));
endmodule

bind fastlock_seq fastlock_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cp_count    (cp_count),
    .sw12_count  (sw12_count),
    .sw3_count   (sw3_count),
    .cp_boost    (cp_boost),
    .sw12_closed (sw12_closed),
    .sw3_closed  (sw3_closed),
    .busy        (busy)
);

// File: tb/sim_fastlock_seq.sv
// Bench for fastlock_seq: directed corner cases plus seeded random runs.
// Inputs change on the falling edge and outputs are read on the next falling edge.
module sim_fastlock_seq;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [W-1:0] cp_count, sw12_count, sw3_count;
    logic         cp_boost, sw12_closed, sw3_closed, busy;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int t_start = 0;
    bit started = 0;
    int lat [3];
    string ctx = "";

    always #4 clk = ~clk;

    fastlock_seq #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cp_count(cp_count), .sw12_count(sw12_count), .sw3_count(sw3_count),
        .cp_boost(cp_boost), .sw12_closed(sw12_closed), .sw3_closed(sw3_closed),
        .busy(busy)
    );

    function automatic bit exp_on(int k);
        return started && ((cyc - t_start) <= lat[k]);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cyc=%0d actual=%b expected=%b", req, ctx, cyc, act, exp);
        end
    endtask

    task automatic check_all();
        bit e0, e1, e2;
        e0 = exp_on(0); e1 = exp_on(1); e2 = exp_on(2);
        chk("R3 cp_boost", cp_boost, e0);
        chk("R4 sw12_closed", sw12_closed, e1);
        chk("R5 sw3_closed", sw3_closed, e2);
        chk("R8 busy", busy, e0 | e1 | e2);
    endtask

    // One reference cycle: drive start, take the edge, model the capture, check.
    task automatic step(bit st);
        start = st;
        @(posedge clk);
        cyc++;
        if (st) begin
            t_start = cyc; started = 1;
            lat[0] = int'(cp_count); lat[1] = int'(sw12_count); lat[2] = int'(sw3_count);
        end
        @(negedge clk);
        start = 1'b0;
        if (st) begin
            chk("R2 cp_boost", cp_boost, 1'b1);
            chk("R2 sw12_closed", sw12_closed, 1'b1);
            chk("R2 sw3_closed", sw3_closed, 1'b1);
            chk("R2 busy", busy, 1'b1);
        end
        check_all();
    endtask

    task automatic set_cfg(int a, int b, int c);
        cp_count = W'(a); sw12_count = W'(b); sw3_count = W'(c);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; set_cfg(0, 0, 0);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        ctx = "R1";
        chk("R1 cp_boost", cp_boost, 1'b0);
        chk("R1 sw12_closed", sw12_closed, 1'b0);
        chk("R1 sw3_closed", sw3_closed, 1'b0);
        chk("R1 busy", busy, 1'b0);
        rst_n = 1'b1;

        // Typical order, then all counts zero.
        ctx = "typical";
        set_cfg(5, 7, 7); step(1);
        for (int i = 0; i < 12; i++) step(0);
        ctx = "zero counts";
        set_cfg(0, 0, 0); step(1);
        for (int i = 0; i < 4; i++) step(0);

        // R6: restart in the middle of a run.
        ctx = "R6 restart";
        set_cfg(6, 9, 3); step(1);
        for (int i = 0; i < 4; i++) step(0);
        step(1);
        for (int i = 0; i < 14; i++) step(0);

        // R7: rewrite the configuration during a run.
        ctx = "R7 cfg change";
        set_cfg(4, 8, 12); step(1);
        step(0); set_cfg(0, 1023, 1);
        for (int i = 0; i < 16; i++) step(0);

        // R9: long idle after expiry, with changing configuration.
        ctx = "R9 idle";
        for (int i = 0; i < 10; i++) begin
            set_cfg(i, i + 1, i + 2); step(0);
        end

        // Maximum count on one timer.
        ctx = "max count";
        set_cfg(1023, 2, 1023); step(1);
        for (int i = 0; i < 1030; i++) step(0);

        // Seeded random runs, with restarts and mid-run config changes.
        ctx = "random";
        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 7) == 0)
                set_cfg($urandom % 48, $urandom % 48, $urandom % 48);
            step(($urandom % 23) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule